// File: doc/BRIEF.md
# Dual-Context Parallel-Port DMA Channel

This block is a byte-wide DMA channel that sits between system memory and a parallel-port device. Software describes up to two buffers in two 64-bit descriptor registers, A and B. Each descriptor holds a base address, a byte length and an end-of-job flag. Software marks a descriptor ready by setting its valid bit in the control register. The engine then serves the descriptors in alternation. For each byte it issues a single-byte memory read or write request, and it moves the byte to or from the device over a ready/valid handshake.

A control register selects the transfer direction, freezes or enables the channel, and can hold the whole channel in reset. A read-only status word reports which descriptor is current, whether the engine is working, and how many bytes remain in the current buffer. The engine refuses a descriptor that would run past a 4 KiB page. It also refuses a descriptor whose inbound base is not 64-byte aligned. In both cases it raises a one-cycle error pulse and moves no data.

Top module: `pdma_top`

## Requirements
- R1: A descriptor word carries the base address in bits 31:0, the byte length in bits 43:32 and the end-of-job flag in bit 63. Other bits read back as zero. Descriptor A sits at register address 0 and descriptor B at address 1.
- R2: The control register sits at address 2, with direction in bit 0, enable in bit 1, channel hold in bit 2, B-valid in bit 3 and A-valid in bit 4. The status word sits at address 3, with the current descriptor in bit 0 (0 = A, 1 = B), busy in bit 1 and the remaining byte count in bits 13:2. The status word is read-only: writes to it leave it unchanged. After reset every register reads zero.
- R3: With direction 0 the engine reads bytes from memory at consecutive ascending addresses starting at the base. It hands each byte to the device in the same order, one per completed handshake.
- R4: With direction 1 the engine takes bytes from the device in arrival order. It writes them to memory at consecutive ascending addresses starting at the base.
- R5: When a descriptor with the end-of-job flag set finishes, `dev_tc` is high for exactly one cycle. This happens after the last byte has been exchanged. A descriptor with the flag clear produces no pulse.
- R6: A descriptor whose base offset within its 4 KiB page plus its length exceeds 0x1000 is not started. `cfg_err` pulses for one cycle, its valid bit clears and no byte moves. A buffer that ends exactly on the page boundary is accepted.
- R7: With direction 1, a base whose low 6 bits are not zero is rejected in the same way as in R6. With direction 0, any byte alignment is accepted.
- R8: After reset the engine serves A first. When a descriptor finishes, its valid bit clears. The engine then moves to the other descriptor if that one is valid; otherwise it idles with busy low. From idle it serves the current descriptor if it is valid, and otherwise the other one.
- R9: A zero-length descriptor finishes at once without any memory or device traffic. It still clears its valid bit and still gives the end-of-job pulse if its flag is set.
- R10: While enable is 0, the channel issues no memory request, no device handshake and no pulse, and it keeps its address pointer and remaining count. Setting enable again resumes the transfer where it stopped.
- R11: While the hold bit is 1, both valid bits read 0, the remaining count is 0, busy is 0, the current descriptor returns to A, and no transfer takes place.
- R12: During a transfer, busy reads 1. The remaining count equals the descriptor length minus the number of bytes whose exchange has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Register write address |
| reg_wdata | input | 64 | Register write data |
| reg_raddr | input | 2 | Register read address |
| reg_rdata | output | 64 | Register read data (combinational) |
| mem_req | output | 1 | Memory byte request |
| mem_we | output | 1 | Request is a write (1) or read (0) |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| mem_ack | input | 1 | Memory completes the request this cycle |
| dev_tx_valid | output | 1 | Byte offered to the device |
| dev_tx_data | output | 8 | Byte to the device |
| dev_tx_ready | input | 1 | Device accepts the byte |
| dev_rx_valid | input | 1 | Device offers a byte |
| dev_rx_data | input | 8 | Byte from the device |
| dev_rx_ready | output | 1 | Engine accepts the byte |
| dev_tc | output | 1 | One-cycle end-of-job pulse to the device |
| cfg_err | output | 1 | One-cycle pulse for a rejected descriptor |

## Verification
The bench sweeps the page-boundary check over every start offset in the last 16 bytes of a page against lengths 1 to 20. A page-check comparator that is off by one would reject buffers ending exactly on the boundary, or would let through a buffer that crosses it by a byte. It freezes an inbound transfer in the middle and watches that count, pointer and handshakes stay put. A design that drops the pointer on freeze, or keeps the handshakes live, would corrupt memory or lose bytes. It checks that the end-of-job pulse comes after the final byte, and that it also comes for zero-length descriptors. Other checks cover the alternation order of A and B, the choice of B when only B is valid, and the channel hold clearing valid bits even when the same write sets them.

// File: rtl/pdma_pkg.sv
// Shared types and register layout for the parallel-port DMA channel.
// Assumes a single clock domain; field positions are fixed by software.
package pdma_pkg;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 12;
    localparam int BYTE_W = 8;

    // Register addresses
    localparam logic [1:0] RA_CTX_A = 2'd0;
    localparam logic [1:0] RA_CTX_B = 2'd1;
    localparam logic [1:0] RA_CTL   = 2'd2;
    localparam logic [1:0] RA_STAT  = 2'd3;

    // Control bit positions
    localparam int CB_DIR  = 0;
    localparam int CB_EN   = 1;
    localparam int CB_HOLD = 2;
    localparam int CB_VB   = 3;
    localparam int CB_VA   = 4;

    // Descriptor field positions
    localparam int DF_LEN_LO = 32;
    localparam int DF_LAST   = 63;

    typedef struct packed {
        logic              last;
        logic [LEN_W-1:0]  len;
        logic [ADDR_W-1:0] base;
    } desc_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD_MEM, ST_SEND, ST_RECV, ST_WR_MEM, ST_DONE
    } eng_state_t;
endpackage

// File: rtl/pdma_regs.sv
// Software register file: two descriptors, control and the read-only
// status word. Hardware clears valid bits through clr_valid; a
// software write to the control register in the same cycle wins.
module pdma_regs
    import pdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [1:0]        waddr,
    input  logic [63:0]       wdata,
    input  logic [1:0]        raddr,
    output logic [63:0]       rdata,
    input  logic [1:0]        clr_valid,
    input  logic              cur_sel,
    input  logic              busy,
    input  logic [LEN_W-1:0]  remain,
    output desc_t             desc_a,
    output desc_t             desc_b,
    output logic              dir,
    output logic              enable,
    output logic              hold,
    output logic [1:0]        valid
);
    logic       dir_n, en_n, hold_n;
    logic [1:0] valid_n;

    // Next control state: hardware clear, then software write, then hold
    always_comb begin
        dir_n   = dir;
        en_n    = enable;
        hold_n  = hold;
        valid_n = valid & ~clr_valid;
        if (we && waddr == RA_CTL) begin
            dir_n   = wdata[CB_DIR];
            en_n    = wdata[CB_EN];
            hold_n  = wdata[CB_HOLD];
            valid_n = {wdata[CB_VB], wdata[CB_VA]};
        end
        if (hold_n) valid_n = 2'b00;
    end

    // Register update for descriptors and control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_a <= '0;
            desc_b <= '0;
            dir    <= 1'b0;
            enable <= 1'b0;
            hold   <= 1'b0;
            valid  <= 2'b00;
        end else begin
            if (we && waddr == RA_CTX_A)
                desc_a <= '{wdata[DF_LAST], wdata[DF_LEN_LO +: LEN_W], wdata[ADDR_W-1:0]};
            if (we && waddr == RA_CTX_B)
                desc_b <= '{wdata[DF_LAST], wdata[DF_LEN_LO +: LEN_W], wdata[ADDR_W-1:0]};
            dir    <= dir_n;
            enable <= en_n;
            hold   <= hold_n;
            valid  <= valid_n;
        end
    end

    // Read multiplexer
    always_comb begin
        rdata = '0;
        case (raddr)
            RA_CTX_A: begin
                rdata[DF_LAST] = desc_a.last;
                rdata[DF_LEN_LO +: LEN_W] = desc_a.len;
                rdata[ADDR_W-1:0] = desc_a.base;
            end
            RA_CTX_B: begin
                rdata[DF_LAST] = desc_b.last;
                rdata[DF_LEN_LO +: LEN_W] = desc_b.len;
                rdata[ADDR_W-1:0] = desc_b.base;
            end
            RA_CTL: begin
                rdata[CB_DIR]  = dir;
                rdata[CB_EN]   = enable;
                rdata[CB_HOLD] = hold;
                rdata[CB_VB]   = valid[1];
                rdata[CB_VA]   = valid[0];
            end
            default: begin
                rdata[0] = cur_sel;
                rdata[1] = busy;
                rdata[2 +: LEN_W] = remain;
            end
        endcase
    end

    // R11: a held channel never reports a valid descriptor
    assert_hold_no_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr == RA_CTL && wdata[CB_HOLD]) |=> (valid == 2'b00));
endmodule

// File: rtl/pdma_ctx_check.sv
// Start-time legality check for a descriptor: page crossing and,
// for inbound transfers, base alignment. Purely combinational.
module pdma_ctx_check #(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 12,
    parameter int PAGE_W  = 12,
    parameter int ALIGN_W = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    input  logic              to_mem,
    output logic              page_fault,
    output logic              align_fault
);
    localparam int SUM_W = ((PAGE_W > LEN_W) ? PAGE_W : LEN_W) + 1;
    localparam logic [SUM_W-1:0] PAGE_BYTES = SUM_W'(1) << PAGE_W;

    logic [SUM_W-1:0] end_off;

    // End offset of the buffer within its page
    always_comb begin
        end_off     = SUM_W'(base[PAGE_W-1:0]) + SUM_W'(len);
        page_fault  = end_off > PAGE_BYTES;
        align_fault = to_mem && (base[ALIGN_W-1:0] != '0);
    end
endmodule

// File: rtl/pdma_engine.sv
// Byte-serial transfer engine. Picks a valid descriptor, checks it,
// then loops one byte at a time between memory and device. Freezes
// in place while enable is low; the hold input resets it entirely.
module pdma_engine
    import pdma_pkg::*;
#(
    parameter int PAGE_W  = 12,
    parameter int ALIGN_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              enable,
    input  logic              dir,
    input  logic [1:0]        valid,
    input  desc_t             desc_a,
    input  desc_t             desc_b,
    output logic [1:0]        clr_valid,
    output logic              cur_sel,
    output logic              busy,
    output logic [LEN_W-1:0]  remain,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tc,
    output logic              err
);
    eng_state_t        state_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [LEN_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] byte_q;
    logic              last_q, dir_q, cur_q;
    logic              run, pick, fault, pf, af;
    desc_t             cand;

    pdma_ctx_check #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_W(PAGE_W), .ALIGN_W(ALIGN_W)
    ) u_check (
        .base(cand.base), .len(cand.len), .to_mem(dir),
        .page_fault(pf), .align_fault(af)
    );

    // Candidate selection and handshake outputs
    always_comb begin
        run       = enable && !hold;
        pick      = valid[cur_q] ? cur_q : !cur_q;
        cand      = pick ? desc_b : desc_a;
        fault     = pf || af;
        err       = run && state_q == ST_IDLE && (valid != 2'b00) && fault;
        mem_req   = run && (state_q == ST_RD_MEM || state_q == ST_WR_MEM);
        mem_we    = state_q == ST_WR_MEM;
        mem_addr  = ptr_q;
        mem_wdata = byte_q;
        tx_valid  = run && state_q == ST_SEND;
        tx_data   = byte_q;
        rx_ready  = run && state_q == ST_RECV;
        tc        = run && state_q == ST_DONE && last_q;
        busy      = run && state_q != ST_IDLE;
        cur_sel   = cur_q;
        remain    = cnt_q;
        clr_valid = 2'b00;
        if (err) clr_valid[pick] = 1'b1;
        if (run && state_q == ST_DONE) clr_valid[cur_q] = 1'b1;
    end

    // Transfer state machine
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            cnt_q   <= '0;
            byte_q  <= '0;
            last_q  <= 1'b0;
            dir_q   <= 1'b0;
            cur_q   <= 1'b0;
        end else if (run) begin
            case (state_q)
                ST_IDLE: if (valid != 2'b00) begin
                    cur_q <= pick;
                    if (!fault) begin
                        ptr_q  <= cand.base;
                        cnt_q  <= cand.len;
                        last_q <= cand.last;
                        dir_q  <= dir;
                        if (cand.len == '0) state_q <= ST_DONE;
                        else state_q <= dir ? ST_RECV : ST_RD_MEM;
                    end
                end
                ST_RD_MEM: if (mem_ack) begin
                    byte_q  <= mem_rdata;
                    state_q <= ST_SEND;
                end
                ST_SEND: if (tx_ready) begin
                    ptr_q   <= ptr_q + 1'b1;
                    cnt_q   <= cnt_q - 1'b1;
                    state_q <= (cnt_q == LEN_W'(1)) ? ST_DONE : ST_RD_MEM;
                end
                ST_RECV: if (rx_valid) begin
                    byte_q  <= rx_data;
                    state_q <= ST_WR_MEM;
                end
                ST_WR_MEM: if (mem_ack) begin
                    ptr_q   <= ptr_q + 1'b1;
                    cnt_q   <= cnt_q - 1'b1;
                    state_q <= (cnt_q == LEN_W'(1)) ? ST_DONE : ST_RECV;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R5: end-of-job pulse lasts one cycle
    assert_tc_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !tc);
    // R10: frozen channel keeps pointer and count
    assert_freeze_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !hold) |=> ($stable(cnt_q) && $stable(ptr_q)));
    // R12: each completed exchange lowers the count by one
    assert_count_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ((state_q == ST_SEND && tx_ready) || (state_q == ST_WR_MEM && mem_ack)))
        |=> (cnt_q == $past(cnt_q) - 1'b1));
    // R6: a rejected descriptor leaves the engine idle
    assert_err_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (state_q == ST_IDLE));
    // R7: inbound transfers only ever start on an aligned base
    assert_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECV && $past(state_q) == ST_IDLE) |-> (ptr_q[ALIGN_W-1:0] == '0));
endmodule

// File: rtl/pdma_top.sv
// Top of the dual-descriptor parallel-port DMA channel: register file
// plus transfer engine. Memory and device sides are single-byte
// handshakes; arbitration lives outside.
module pdma_top
    import pdma_pkg::*;
#(
    parameter int PAGE_W  = 12,
    parameter int ALIGN_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_waddr,
    input  logic [63:0]       reg_wdata,
    input  logic [1:0]        reg_raddr,
    output logic [63:0]       reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic              dev_tx_valid,
    output logic [BYTE_W-1:0] dev_tx_data,
    input  logic              dev_tx_ready,
    input  logic              dev_rx_valid,
    input  logic [BYTE_W-1:0] dev_rx_data,
    output logic              dev_rx_ready,
    output logic              dev_tc,
    output logic              cfg_err
);
    desc_t            desc_a, desc_b;
    logic             dir, enable, hold, cur_sel, busy;
    logic [1:0]       valid, clr_valid;
    logic [LEN_W-1:0] remain;

    pdma_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
        .raddr(reg_raddr), .rdata(reg_rdata), .clr_valid(clr_valid),
        .cur_sel(cur_sel), .busy(busy), .remain(remain),
        .desc_a(desc_a), .desc_b(desc_b), .dir(dir), .enable(enable),
        .hold(hold), .valid(valid)
    );

    pdma_engine #(.PAGE_W(PAGE_W), .ALIGN_W(ALIGN_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .hold(hold), .enable(enable), .dir(dir),
        .valid(valid), .desc_a(desc_a), .desc_b(desc_b), .clr_valid(clr_valid),
        .cur_sel(cur_sel), .busy(busy), .remain(remain),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .tx_valid(dev_tx_valid), .tx_data(dev_tx_data), .tx_ready(dev_tx_ready),
        .rx_valid(dev_rx_valid), .rx_data(dev_rx_data), .rx_ready(dev_rx_ready),
        .tc(dev_tc), .err(cfg_err)
    );

    // R11: a channel held for two cycles reports nothing in flight
    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hold) && hold) |-> (!busy && remain == '0 && !cur_sel));
    // R8: a finished descriptor's valid bit drops unless software rewrote it
    assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_valid[0] && !(reg_we && reg_waddr == RA_CTL)) |=> !valid[0]);
endmodule

// File: tb/pdma_top_tb.sv
module pdma_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_waddr = '0;
    logic [63:0] reg_wdata = '0;
    logic [1:0]  reg_raddr = '0;
    logic [63:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        dev_tx_valid, dev_tx_ready, dev_rx_valid, dev_rx_ready, dev_tc, cfg_err;
    logic [7:0]  dev_tx_data, dev_rx_data;

    pdma_top u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .dev_tx_valid(dev_tx_valid), .dev_tx_data(dev_tx_data), .dev_tx_ready(dev_tx_ready),
        .dev_rx_valid(dev_rx_valid), .dev_rx_data(dev_rx_data), .dev_rx_ready(dev_rx_ready),
        .dev_tc(dev_tc), .cfg_err(cfg_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench models: memory, device sink and source, event counters
    logic [7:0]  bmem   [0:16383];
    logic [7:0]  tx_log [0:16383];
    int          tx_cnt = 0, wr_cnt = 0, rx_idx = 0, tc_cnt = 0, err_cnt = 0;
    int          tc_tx_mark = 0, tc_wr_mark = 0, cyc = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic        stall = 1'b0;
    logic        ack_ok = 1'b1, txr_ok = 1'b1, rxv_ok = 1'b1;
    int          n_chk = 0, n_err = 0;

    function automatic logic [7:0] rx_pat(input int i);
        return 8'((i * 13) + 5);
    endfunction

    assign mem_rdata    = bmem[mem_addr[13:0]];
    assign mem_ack      = ack_ok;
    assign dev_tx_ready = txr_ok;
    assign dev_rx_valid = rxv_ok;
    assign dev_rx_data  = rx_pat(rx_idx);

    always @(negedge clk) begin
        lfsr   <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ack_ok <= stall ? lfsr[0] : 1'b1;
        txr_ok <= stall ? lfsr[3] : 1'b1;
        rxv_ok <= stall ? lfsr[7] : 1'b1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_req && mem_we && mem_ack) begin
            bmem[mem_addr[13:0]] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
        if (dev_tx_valid && dev_tx_ready) begin
            tx_log[tx_cnt[13:0]] <= dev_tx_data;
            tx_cnt <= tx_cnt + 1;
        end
        if (dev_rx_valid && dev_rx_ready) rx_idx <= rx_idx + 1;
        if (dev_tc) begin
            tc_cnt <= tc_cnt + 1;
            tc_tx_mark <= tx_cnt;
            tc_wr_mark <= wr_cnt;
        end
        if (cfg_err) err_cnt <= err_cnt + 1;
    end

    always @(posedge clk) begin
        if (cyc > WATCHDOG) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [63:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [63:0] mk_desc(input logic last, input int len, input logic [31:0] base);
        return {last, 19'b0, 12'(len), base};
    endfunction

    function automatic logic [63:0] mk_ctl(input logic va, input logic vb, input logic hd,
                                           input logic en, input logic dr);
        return {59'b0, va, vb, hd, en, dr};
    endfunction

    task automatic wait_done(input string req);
        logic [63:0] c, s;
        for (int k = 0; k < 20000; k++) begin
            @(negedge clk);
            rd(2'd2, c);
            rd(2'd3, s);
            if (c[4:3] == 2'b00 && s[1] == 1'b0) return;
        end
        chk(req, 64'hDEAD, 64'h0);
    endtask

    task automatic wait_cycles(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Outbound run of one descriptor in slot A; checks data, pulse, valid clear
    task automatic run_out(input logic [31:0] base, input int len, input logic last);
        int t0, c0, bad;
        logic [63:0] v;
        t0 = tx_cnt; c0 = tc_cnt;
        wr(2'd0, mk_desc(last, len, base));
        wr(2'd2, mk_ctl(1, 0, 0, 1, 0));
        wait_done("R3");
        chk("R3 byte count", 64'(tx_cnt - t0), 64'(len));
        bad = 0;
        for (int i = 0; i < len; i++)
            if (tx_log[14'(t0 + i)] !== bmem[14'(base + i)]) bad++;
        chk("R3 byte order/value mismatches", 64'(bad), 64'd0);
        chk("R5 tc count", 64'(tc_cnt - c0), last ? 64'd1 : 64'd0);
        if (last) chk("R5 tc after last byte", 64'(tc_tx_mark), 64'(t0 + len));
        rd(2'd2, v);
        chk("R8 valid A cleared", 64'(v[4]), 64'd0);
    endtask

    initial begin
        logic [63:0] v, s;
        int t0, c0, e0, w0, r0, bad, w1, r1;
        logic [11:0] cnt1;
        int lens [7] = '{1, 2, 3, 4, 7, 16, 33};

        for (int i = 0; i < 16384; i++) bmem[i] = 8'((i * 7) ^ (i >> 3) ^ 8'h5A);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        rd(2'd2, v); chk("R2 ctl after reset", v, 64'd0);
        rd(2'd3, v); chk("R2 status after reset", v, 64'd0);
        rd(2'd0, v); chk("R2 desc A after reset", v, 64'd0);
        chk("R2 no request after reset", 64'(mem_req), 64'd0);

        // R1: descriptor layout readback, reserved bits zero
        wr(2'd0, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(2'd0, v); chk("R1 desc A mask", v, 64'h8000_0FFF_FFFF_FFFF);
        wr(2'd1, 64'h7AB0_0123_8765_4321);
        rd(2'd1, v); chk("R1 desc B fields", v, 64'h0000_0123_8765_4321);

        // R2: status write ignored
        wr(2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(2'd3, v); chk("R2 status read-only", v, 64'd0);
        wr(2'd1, 64'd0);

        // R3 R5: outbound sweep over lengths and alignments, with and without stalls
        for (int li = 0; li < 7; li++)
            for (int off = 0; off < 4; off++) begin
                stall = off[0];
                run_out(32'h200 + 32'(li * 64) + 32'(off), lens[li], 1'b1);
            end
        stall = 1'b0;

        // R5: end-of-job flag clear gives no pulse
        run_out(32'h0800, 5, 1'b0);

        // R9: zero length, with and without the flag
        t0 = tx_cnt; c0 = tc_cnt;
        wr(2'd0, mk_desc(1, 0, 32'h0900));
        wr(2'd2, mk_ctl(1, 0, 0, 1, 0));
        wait_done("R9");
        chk("R9 zero length moves nothing", 64'(tx_cnt - t0), 64'd0);
        chk("R9 zero length still pulses", 64'(tc_cnt - c0), 64'd1);
        rd(2'd2, v); chk("R9 zero length clears valid", 64'(v[4]), 64'd0);
        c0 = tc_cnt;
        wr(2'd0, mk_desc(0, 0, 32'h0900));
        wr(2'd2, mk_ctl(1, 0, 0, 1, 0));
        wait_done("R9");
        chk("R9 zero length no flag no pulse", 64'(tc_cnt - c0), 64'd0);

        // R4 R10 R12: inbound transfer frozen mid-way, then resumed
        stall = 1'b1;
        w0 = wr_cnt; r0 = rx_idx; c0 = tc_cnt;
        wr(2'd0, mk_desc(1, 37, 32'h1400));
        wr(2'd2, mk_ctl(1, 0, 0, 1, 1));
        for (int k = 0; k < 5000 && (wr_cnt - w0) < 10; k++) @(negedge clk);
        rd(2'd3, s); chk("R12 busy during transfer", 64'(s[1]), 64'd1);
        wr(2'd2, mk_ctl(1, 0, 0, 0, 1));
        rd(2'd3, s);
        cnt1 = s[13:2]; w1 = wr_cnt; r1 = rx_idx;
        chk("R12 remaining count", 64'(cnt1), 64'(37 - (w1 - w0)));
        wait_cycles(20);
        rd(2'd3, s);
        chk("R10 count held while frozen", 64'(s[13:2]), 64'(cnt1));
        chk("R10 busy low while frozen", 64'(s[1]), 64'd0);
        chk("R10 no memory writes while frozen", 64'(wr_cnt), 64'(w1));
        chk("R10 no device bytes while frozen", 64'(rx_idx), 64'(r1));
        chk("R10 no request while frozen", 64'({mem_req, dev_rx_ready}), 64'd0);
        wr(2'd2, mk_ctl(1, 0, 0, 1, 1));
        wait_done("R10");
        chk("R4 bytes written", 64'(wr_cnt - w0), 64'd37);
        bad = 0;
        for (int i = 0; i < 37; i++)
            if (bmem[14'(32'h1400 + i)] !== rx_pat(r0 + i)) bad++;
        chk("R4 inbound data mismatches", 64'(bad), 64'd0);
        chk("R5 inbound tc after last write", 64'(tc_wr_mark), 64'(w0 + 37));
        chk("R5 inbound tc count", 64'(tc_cnt - c0), 64'd1);
        stall = 1'b0;

        // R7: misaligned inbound base is rejected
        w0 = wr_cnt; e0 = err_cnt; c0 = tc_cnt;
        wr(2'd0, mk_desc(1, 8, 32'h1404));
        wr(2'd2, mk_ctl(1, 0, 0, 1, 1));
        wait_done("R7");
        chk("R7 misaligned inbound error", 64'(err_cnt - e0), 64'd1);
        chk("R7 misaligned inbound no write", 64'(wr_cnt - w0), 64'd0);
        chk("R7 misaligned inbound no pulse", 64'(tc_cnt - c0), 64'd0);
        rd(2'd2, v); chk("R7 misaligned clears valid", 64'(v[4]), 64'd0);

        // R6: page-boundary sweep near the end of a page
        for (int off = 0; off < 16; off++)
            for (int len = 1; len <= 20; len++) begin
                t0 = tx_cnt; e0 = err_cnt;
                wr(2'd0, mk_desc(0, len, 32'h0FF0 + 32'(off)));
                wr(2'd2, mk_ctl(1, 0, 0, 1, 0));
                wait_done("R6");
                chk("R6 page error", 64'(err_cnt - e0), (off + len > 16) ? 64'd1 : 64'd0);
                chk("R6 page bytes", 64'(tx_cnt - t0), (off + len > 16) ? 64'd0 : 64'(len));
            end

        // R11: channel hold during a transfer
        wr(2'd0, mk_desc(0, 200, 32'h2000));
        wr(2'd1, mk_desc(0, 10, 32'h2100));
        t0 = tx_cnt;
        wr(2'd2, mk_ctl(1, 1, 0, 1, 0));
        for (int k = 0; k < 2000 && (tx_cnt - t0) < 5; k++) @(negedge clk);
        wr(2'd2, mk_ctl(1, 1, 1, 1, 0));
        @(negedge clk);
        rd(2'd2, v); chk("R11 hold clears valid bits", 64'(v[4:3]), 64'd0);
        rd(2'd3, s); chk("R11 hold clears status", s, 64'd0);
        t0 = tx_cnt;
        wait_cycles(10);
        chk("R11 no traffic while held", 64'(tx_cnt - t0), 64'd0);
        wr(2'd2, mk_ctl(0, 0, 0, 1, 0));
        wait_cycles(3);
        rd(2'd3, s); chk("R11 idle after release", s, 64'd0);

        // R8: alternation A then B, starting with A
        t0 = tx_cnt; c0 = tc_cnt;
        wr(2'd0, mk_desc(0, 9, 32'h3000));
        wr(2'd1, mk_desc(1, 6, 32'h3100));
        wr(2'd2, mk_ctl(1, 1, 0, 1, 0));
        wait_done("R8");
        chk("R8 total bytes", 64'(tx_cnt - t0), 64'd15);
        bad = 0;
        for (int i = 0; i < 9; i++) if (tx_log[14'(t0 + i)] !== bmem[14'(32'h3000 + i)]) bad++;
        for (int i = 0; i < 6; i++) if (tx_log[14'(t0 + 9 + i)] !== bmem[14'(32'h3100 + i)]) bad++;
        chk("R8 A then B order mismatches", 64'(bad), 64'd0);
        chk("R8 only B pulses", 64'(tc_cnt - c0), 64'd1);
        chk("R5 pulse after B's last byte", 64'(tc_tx_mark), 64'(t0 + 15));
        rd(2'd3, s); chk("R8 current is B, idle", s, 64'd1);

        // R8: only A valid while current is B -> A served
        t0 = tx_cnt;
        wr(2'd0, mk_desc(0, 4, 32'h3200));
        wr(2'd2, mk_ctl(1, 0, 0, 1, 0));
        wait_done("R8");
        chk("R8 other descriptor served", 64'(tx_cnt - t0), 64'd4);
        chk("R8 served bytes from A", 64'(tx_log[14'(t0)]), 64'(bmem[14'h3200]));
        rd(2'd3, s); chk("R8 current back to A", s, 64'd0);

        // R8: only B valid while current is A -> B served
        t0 = tx_cnt;
        wr(2'd1, mk_desc(0, 3, 32'h3300));
        wr(2'd2, mk_ctl(0, 1, 0, 1, 0));
        wait_done("R8");
        chk("R8 B served from A", 64'(tx_log[14'(t0)]), 64'(bmem[14'h3300]));
        rd(2'd3, s); chk("R8 current is B", s, 64'd1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule